// File: doc/BRIEF.md
# Asymmetric Two-Pipe Warp Issue Stage

This block sits between an instruction queue and two 16-lane execution pipes. Each cycle it may take one 32-thread warp instruction over a valid/ready handshake. The instruction carries an operation-class bit (float or integer), a warp identifier and an opcode tag. The block steers the instruction to one of two pipes and then plays it out over two consecutive cycles, one 16-lane half per cycle.

The two pipes are not equal. The float pipe accepts only floating-point work. The shared pipe accepts either floating-point or integer work. A pipe can take a new warp in the same cycle in which it shows the second half of its current warp. Because of this, a stream of float instructions can be accepted every cycle, alternating between the pipes. Integer work has only the shared pipe, so back-to-back integer instructions stall on every second one. At most 32 lanes are active in any cycle: 32 float lanes, or 16 float lanes plus 16 integer lanes.

A counter for each pipe records how many warp instructions that pipe has completed. This lets throughput under a given float/integer mix be measured at the ports.

Top module: `warp_dual_dispatch`

## Requirements
- R1: After a synchronous active-high reset, both pipe outputs are invalid, both completion counts are zero, and `in_ready` is high.
- R2: An accepted integer instruction (`in_is_int`=1) appears on the shared pipe in the next cycle with `pb_is_int`=1, half 0, and its warp and tag. The float pipe always shows `pa_is_int`=0.
- R3: An accepted float instruction goes to the float pipe when that pipe is open, and to the shared pipe otherwise. A pipe is open when it is idle or shows half 1. The chosen pipe shows the instruction's warp and tag, half 0, in the next cycle.
- R4: Every dispatched warp is shown on its pipe for exactly two consecutive cycles, half 0 (lanes 0-15) and then half 1 (lanes 16-31), with the same warp and tag. After that the pipe goes idle unless it has been reloaded.
- R5: `in_ready` is low for an integer instruction while the shared pipe shows half 0. A stalled instruction is held by the source and is accepted once the shared pipe opens. A float instruction is never stalled.
- R6: A run of float instructions offered in consecutive cycles is accepted one per cycle with no bubble.
- R7: In no cycle do both pipes show half 0, so at most one new warp starts per cycle and no more than 32 lanes are active.
- R8: A pipe's completion count rises by one in the cycle after that pipe shows half 1, and otherwise holds. It wraps modulo 2^CNT_W.
- R9: With `in_valid` low, no instruction is taken: in the next cycle neither pipe starts a new half 0, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_is_int | input | 1 | 1 = integer class, 0 = float class |
| in_warp | input | WARP_W | Warp identifier |
| in_tag | input | TAG_W | Opcode tag |
| pa_valid | output | 1 | Float pipe issues a half this cycle |
| pa_half | output | 1 | Float pipe half select (0 = lanes 0-15, 1 = lanes 16-31) |
| pa_warp | output | WARP_W | Float pipe warp identifier |
| pa_tag | output | TAG_W | Float pipe opcode tag |
| pa_is_int | output | 1 | Float pipe class bit (always 0) |
| pb_valid | output | 1 | Shared pipe issues a half this cycle |
| pb_half | output | 1 | Shared pipe half select |
| pb_warp | output | WARP_W | Shared pipe warp identifier |
| pb_tag | output | TAG_W | Shared pipe opcode tag |
| pb_is_int | output | 1 | Shared pipe class bit |
| pa_done_cnt | output | CNT_W | Warps completed on the float pipe |
| pb_done_cnt | output | CNT_W | Warps completed on the shared pipe |

## Verification
A wrong occupancy bit shows up one cycle later. Either `in_ready` drops for an integer instruction that should pass, or a pipe skips or repeats a half. A half that is out of place also shifts that pipe's completion count one cycle after the bad half. Wrong steering places a warp and tag on the wrong pipe in the cycle right after the handshake, or lets both pipes show half 0 together. The random mix of classes, with stalled instructions held at the source, reaches every combination of occupancy within a few dozen cycles.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_FLT  = 2'd1,
    TGT_SHR  = 2'd2
  } tgt_e;

  // A pipe can take new work when idle or when showing its last half.
  function automatic logic slot_open(input logic vld, input logic hlf);
    return !vld || hlf;
  endfunction

  // Target choice: integer only to the shared pipe; float prefers the float pipe.
  function automatic tgt_e pick_target(input logic is_int,
                                       input logic open_flt,
                                       input logic open_shr);
    if (is_int)   return open_shr ? TGT_SHR : TGT_NONE;
    if (open_flt) return TGT_FLT;
    if (open_shr) return TGT_SHR;
    return TGT_NONE;
  endfunction

endpackage

// File: rtl/wd_steer.sv
module wd_steer
  import wd_pkg::*;
(
  input  logic       in_valid,
  input  logic       in_is_int,
  input  logic [1:0] open_vec,
  output logic       ready,
  output logic [1:0] load_vec
);
  tgt_e tgt;

  always_comb begin
    tgt         = pick_target(in_is_int, open_vec[0], open_vec[1]);
    ready       = (tgt != TGT_NONE);
    load_vec[0] = in_valid && (tgt == TGT_FLT);
    load_vec[1] = in_valid && (tgt == TGT_SHR);
  end
endmodule

// File: rtl/wd_slot.sv
module wd_slot
  import wd_pkg::*;
#(
  parameter int WARP_W = 5,
  parameter int TAG_W  = 8,
  parameter bit INT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WARP_W-1:0] ld_warp,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              ld_int,
  output logic              open,
  output logic              retire,
  output logic              o_valid,
  output logic              o_half,
  output logic [WARP_W-1:0] o_warp,
  output logic [TAG_W-1:0]  o_tag,
  output logic              o_int
);
  logic              vld_q, hlf_q, int_q;
  logic [WARP_W-1:0] warp_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      hlf_q <= 1'b0;
      int_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
      hlf_q <= 1'b0;
      int_q <= INT_OK ? ld_int : 1'b0;
    end else if (vld_q && !hlf_q) begin
      hlf_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
      hlf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      warp_q <= ld_warp;
      tag_q  <= ld_tag;
    end
  end

  assign open    = slot_open(vld_q, hlf_q);
  assign retire  = vld_q && hlf_q;
  assign o_valid = vld_q;
  assign o_half  = hlf_q;
  assign o_warp  = warp_q;
  assign o_tag   = tag_q;
  assign o_int   = int_q;
endmodule

// File: rtl/wd_tally.sv
module wd_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/warp_dual_dispatch.sv
module warp_dual_dispatch #(
  parameter int WARP_W = 5,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_int,
  input  logic [WARP_W-1:0] in_warp,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              pa_valid,
  output logic              pa_half,
  output logic [WARP_W-1:0] pa_warp,
  output logic [TAG_W-1:0]  pa_tag,
  output logic              pa_is_int,
  output logic              pb_valid,
  output logic              pb_half,
  output logic [WARP_W-1:0] pb_warp,
  output logic [TAG_W-1:0]  pb_tag,
  output logic              pb_is_int,
  output logic [CNT_W-1:0]  pa_done_cnt,
  output logic [CNT_W-1:0]  pb_done_cnt
);
  localparam int NPIPE = 2;

  logic [NPIPE-1:0]  slot_open, slot_load, slot_retire;
  logic [NPIPE-1:0]  slot_valid, slot_half, slot_int;
  logic [WARP_W-1:0] slot_warp [NPIPE];
  logic [TAG_W-1:0]  slot_tag  [NPIPE];
  logic [CNT_W-1:0]  slot_cnt  [NPIPE];

  // Named event for the checker: handshake taken this cycle.
  logic accept;

  wd_steer u_steer (
    .in_valid (in_valid),
    .in_is_int(in_is_int),
    .open_vec (slot_open),
    .ready    (in_ready),
    .load_vec (slot_load)
  );

  assign accept = in_valid && in_ready;

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    wd_slot #(
      .WARP_W(WARP_W),
      .TAG_W (TAG_W),
      .INT_OK(g == 1)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .load   (slot_load[g]),
      .ld_warp(in_warp),
      .ld_tag (in_tag),
      .ld_int (in_is_int),
      .open   (slot_open[g]),
      .retire (slot_retire[g]),
      .o_valid(slot_valid[g]),
      .o_half (slot_half[g]),
      .o_warp (slot_warp[g]),
      .o_tag  (slot_tag[g]),
      .o_int  (slot_int[g])
    );

    wd_tally #(.CNT_W(CNT_W)) u_tally (
      .clk(clk),
      .rst(rst),
      .inc(slot_retire[g]),
      .cnt(slot_cnt[g])
    );
  end

  assign pa_valid    = slot_valid[0];
  assign pa_half     = slot_half[0];
  assign pa_warp     = slot_warp[0];
  assign pa_tag      = slot_tag[0];
  assign pa_is_int   = slot_int[0];
  assign pb_valid    = slot_valid[1];
  assign pb_half     = slot_half[1];
  assign pb_warp     = slot_warp[1];
  assign pb_tag      = slot_tag[1];
  assign pb_is_int   = slot_int[1];
  assign pa_done_cnt = slot_cnt[0];
  assign pb_done_cnt = slot_cnt[1];
endmodule

// File: rtl/warp_dual_dispatch_chk.sv
module warp_dual_dispatch_chk #(
  parameter int WARP_W = 5,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_int,
  input logic              pa_valid,
  input logic              pa_half,
  input logic [WARP_W-1:0] pa_warp,
  input logic [TAG_W-1:0]  pa_tag,
  input logic              pa_is_int,
  input logic              pb_valid,
  input logic              pb_half,
  input logic [WARP_W-1:0] pb_warp,
  input logic [TAG_W-1:0]  pb_tag,
  input logic              pb_is_int,
  input logic [CNT_W-1:0]  pa_done_cnt,
  input logic [CNT_W-1:0]  pb_done_cnt
);
  AST_INT_TO_SHARED: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_is_int |=> pb_valid && !pb_half && pb_is_int); // R2
  AST_FLOAT_PIPE_NO_INT: assert property (@(posedge clk) disable iff (rst)
    pa_valid |-> !pa_is_int); // R2
  AST_PA_SECOND_HALF: assert property (@(posedge clk) disable iff (rst)
    pa_valid && !pa_half |=> pa_valid && pa_half && $stable(pa_warp) && $stable(pa_tag)); // R4
  AST_PB_SECOND_HALF: assert property (@(posedge clk) disable iff (rst)
    pb_valid && !pb_half |=> pb_valid && pb_half && $stable(pb_warp) && $stable(pb_tag)); // R4
  AST_INT_STALL: assert property (@(posedge clk) disable iff (rst)
    in_is_int && pb_valid && !pb_half |-> !in_ready); // R5
  AST_FLOAT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !in_is_int |-> in_ready); // R5
  AST_ONE_NEW_HALF: assert property (@(posedge clk) disable iff (rst)
    !(pa_valid && !pa_half && pb_valid && !pb_half)); // R7
  AST_PA_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    pa_valid && pa_half |=> pa_done_cnt == CNT_W'($past(pa_done_cnt) + 1'b1)); // R8
  AST_PA_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(pa_valid && pa_half) |=> $stable(pa_done_cnt)); // R8
  AST_PB_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    pb_valid && pb_half |=> pb_done_cnt == CNT_W'($past(pb_done_cnt) + 1'b1)); // R8
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(pa_valid && !pa_half) && !(pb_valid && !pb_half)); // R9
endmodule

bind warp_dual_dispatch warp_dual_dispatch_chk #(
  .WARP_W(WARP_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_is_int(in_is_int),
  .pa_valid(pa_valid), .pa_half(pa_half), .pa_warp(pa_warp), .pa_tag(pa_tag),
  .pa_is_int(pa_is_int),
  .pb_valid(pb_valid), .pb_half(pb_half), .pb_warp(pb_warp), .pb_tag(pb_tag),
  .pb_is_int(pb_is_int),
  .pa_done_cnt(pa_done_cnt), .pb_done_cnt(pb_done_cnt)
);

// File: tb/warp_dual_dispatch_tb.sv
module warp_dual_dispatch_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_is_int = 1'b0;
  logic [4:0] in_warp = '0;
  logic [7:0] in_tag = '0;
  logic       in_ready;
  logic       pa_valid, pa_half, pa_is_int, pb_valid, pb_half, pb_is_int;
  logic [4:0] pa_warp, pb_warp;
  logic [7:0] pa_tag, pb_tag;
  logic [15:0] pa_done_cnt, pb_done_cnt;

  int checks = 0, fails = 0;

  // Reference state per pipe: valid, half, warp, tag, class, completions
  logic        mA_v = 0, mA_h = 0, mB_v = 0, mB_h = 0, mB_i = 0;
  logic [4:0]  mA_w, mB_w;
  logic [7:0]  mA_t, mB_t;
  logic [15:0] cA = 0, cB = 0;
  int          took = 0;

  always #2 clk = ~clk; // 250 MHz

  warp_dual_dispatch u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_int(in_is_int), .in_warp(in_warp), .in_tag(in_tag),
    .pa_valid(pa_valid), .pa_half(pa_half), .pa_warp(pa_warp), .pa_tag(pa_tag),
    .pa_is_int(pa_is_int),
    .pb_valid(pb_valid), .pb_half(pb_half), .pb_warp(pb_warp), .pb_tag(pb_tag),
    .pb_is_int(pb_is_int),
    .pa_done_cnt(pa_done_cnt), .pb_done_cnt(pb_done_cnt)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected readiness from the requirements (R5): an integer op waits while
  // the shared pipe is in its first half; a float op needs either pipe not in
  // its first half.
  function automatic logic exp_ready(input logic is_int);
    logic a_busy, b_busy;
    a_busy = mA_v & ~mA_h;
    b_busy = mB_v & ~mB_h;
    return is_int ? ~b_busy : ~(a_busy & b_busy);
  endfunction

  // One cycle: drive, compare, then advance the reference past the next edge.
  task automatic step(input logic v, input logic ii, input logic [4:0] w,
                      input logic [7:0] t, output logic acc);
    logic to_a, to_b;
    @(negedge clk);
    in_valid = v; in_is_int = ii; in_warp = w; in_tag = t;
    #1;
    chk(pa_valid, mA_v, "R4 pa_valid");
    chk(pb_valid, mB_v, "R4 pb_valid");
    if (mA_v) begin
      chk(pa_half, mA_h, "R4 pa_half");
      chk({pa_warp, pa_tag}, {mA_w, mA_t}, "R3 pa warp/tag");
      chk(pa_is_int, 1'b0, "R2 pa class");
    end
    if (mB_v) begin
      chk(pb_half, mB_h, "R4 pb_half");
      chk({pb_warp, pb_tag}, {mB_w, mB_t}, "R3 pb warp/tag");
      chk(pb_is_int, mB_i, "R2 pb class");
    end
    chk(!(pa_valid && !pa_half && pb_valid && !pb_half), 1'b1, "R7 one new half");
    chk(pa_done_cnt, cA, "R8 pa count");
    chk(pb_done_cnt, cB, "R8 pb count");
    chk(in_ready, exp_ready(ii), "R5 ready");
    acc  = v && exp_ready(ii);
    to_a = acc && !ii && !(mA_v && !mA_h);
    to_b = acc && !to_a;
    if (acc) took++;
    if (mA_v && mA_h) cA++;
    if (mB_v && mB_h) cB++;
    if (to_a) begin mA_v = 1; mA_h = 0; mA_w = w; mA_t = t; end
    else if (mA_v && !mA_h) mA_h = 1;
    else begin mA_v = 0; mA_h = 0; end
    if (to_b) begin mB_v = 1; mB_h = 0; mB_w = w; mB_t = t; mB_i = ii; end
    else if (mB_v && !mB_h) mB_h = 1;
    else begin mB_v = 0; mB_h = 0; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    logic acc;
    logic pv, pi;
    logic [4:0] pw;
    logic [7:0] pt;
    void'($urandom(32'h5eed_0147));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk({pa_valid, pb_valid}, 2'b00, "R1 no valid after reset");
    chk({pa_done_cnt, pb_done_cnt}, 32'h0, "R1 counts zero");
    chk(in_ready, 1'b1, "R1 ready after reset");

    // R2/R5: integer, then integer again stalls, then passes
    step(1, 1, 5'd1, 8'hA1, acc); chk(acc, 1'b1, "R2 int taken");
    step(1, 1, 5'd2, 8'hA2, acc); chk(acc, 1'b0, "R5 int stalls on busy shared pipe");
    step(1, 1, 5'd2, 8'hA2, acc); chk(acc, 1'b1, "R5 held int accepted");
    chk({pb_valid, pb_half, pb_warp}, {1'b1, 1'b1, 5'd1}, "R4 first int second half");
    // R9: idle with junk data on the inputs
    step(0, 0, 5'd7, 8'hFF, acc);
    step(0, 1, 5'd9, 8'hEE, acc);
    chk((pa_valid && !pa_half) || (pb_valid && !pb_half), 1'b0, "R9 idle starts nothing");
    step(0, 0, 5'd0, 8'h00, acc);

    // R3: float to float pipe, next float to shared pipe, third back to float pipe
    step(1, 0, 5'd3, 8'hB1, acc);
    step(1, 0, 5'd4, 8'hB2, acc);
    chk({pa_valid, pa_half, pa_warp}, {1'b1, 1'b0, 5'd3}, "R3 float prefers float pipe");
    step(1, 0, 5'd5, 8'hB3, acc);
    chk({pb_valid, pb_half, pb_warp}, {1'b1, 1'b0, 5'd4}, "R3 float overflows to shared pipe");
    step(0, 0, 5'd0, 8'h00, acc);
    chk({pa_valid, pa_half, pa_warp}, {1'b1, 1'b0, 5'd5}, "R3 float pipe reused after half 1");

    // R6: ten floats back to back, no bubble
    took = 0;
    for (int k = 0; k < 10; k++) step(1, 0, 5'(k), 8'(8'h40 + k), acc);
    chk(took, 10, "R6 one float per cycle");
    for (int k = 0; k < 3; k++) step(0, 0, 5'd0, 8'h00, acc);
    chk(pa_done_cnt, cA, "R8 float pipe tally after run");

    // Random mix; stalled instructions are held at the source
    pv = 0; pi = 0; pw = '0; pt = '0;
    for (int n = 0; n < 4000; n++) begin
      if (!pv) begin
        pv = ($urandom_range(9) < 7);
        pi = ($urandom_range(9) < 4);
        pw = 5'($urandom);
        pt = 8'($urandom);
      end
      step(pv, pi, pw, pt, acc);
      if (acc) pv = 0;
    end
    for (int k = 0; k < 3; k++) step(0, 0, 5'd0, 8'h00, acc);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule